// File: doc/BRIEF.md
# PC-relative conditional branch unit

This block resolves the short conditional branch form of a small processor with 16-bit instruction words. Each cycle it takes the instruction word, the address of that instruction and a five-flag condition register written by the last compare. From these it produces three results: the address of the next instruction, a flag that says the branch was taken, and a flag that reports an illegal instruction.

The branch target is the instruction's own address plus an offset carried in the instruction. The offset is signed and counts halfwords. Ten branch conditions are decoded. Signed and unsigned ordering use separate flags. Branch opcodes with no assigned condition trap as illegal. So do the retired long-form branch codes, which once carried an absolute 32-bit target in a second word.

With the default `REG_OUT = 1`, all three results pass through one register stage with an asynchronous active-low reset. With `REG_OUT = 0` the block is purely combinational.

Top module: `brc_unit`

## Requirements
- R1: A word with bits [15:14] = 2'b11 is a short branch, and its opcode is bits [13:10]. Words with [15:14] = 2'b01 or 2'b10 are not branches and not retired codes. They give next PC = PC + 2, with taken and illegal both low.
- R2: The offset field is bits [9:0]. It is sign-extended from bit 9 and multiplied by 2. Field 0x1FF gives +1022 bytes and field 0x200 gives -1024 bytes.
- R3: The flag bits are flags_i[0] equal, [1] signed-less, [2] signed-greater, [3] unsigned-less and [4] unsigned-greater. Opcode 0 branches on equal and opcode 1 on equal clear. Opcodes 2, 3, 4 and 5 branch on signed-less, signed-greater, unsigned-less and unsigned-greater respectively.
- R4: Opcodes 6, 7, 8 and 9 branch when the equal flag is set, or when the flag for signed-greater, signed-less, unsigned-greater or unsigned-less respectively is set.
- R5: A taken branch gives next PC = PC + scaled offset, modulo 2^32.
- R6: A short branch whose condition fails gives next PC = PC + 2, with taken low.
- R7: Short-branch opcodes 10 to 15 raise illegal. They keep taken low and give next PC = PC.
- R8: A word with bits [15:14] = 2'b00 and bits [15:8] in 0x0F..0x18 (retired long branches) raises illegal and gives next PC = PC. The codes 0x0E and 0x19 do not raise illegal.
- R9: taken_o and illegal_o are never high together.
- R10: Bit 0 of next_pc_o is always 0, even when pc_i is odd.
- R11: With REG_OUT = 1, the results for the inputs present at a rising clock edge appear after that edge. While rst_ni is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| inst_i | input | 16 | Current instruction word |
| pc_i | input | 32 | Address of the current instruction |
| flags_i | input | 5 | Compare flags: eq, lt, gt, ltu, gtu (bit 0 upward) |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | Short branch taken |
| illegal_o | output | 1 | Illegal-instruction exception |

## Verification
With the default register stage, every result is due exactly one rising edge after its inputs are presented. Nothing in the block takes more than one cycle. The bench drives inputs on a falling edge, lets one rising edge pass, and samples all three outputs on the next falling edge. Each sample is therefore taken half a period away from any edge that could change the outputs. Reset behaviour is checked without a clock edge: the outputs are sampled shortly after rst_ni falls, while it is still low.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int unsigned FLAG_W = 5;
  localparam int unsigned FL_EQ  = 0;
  localparam int unsigned FL_LT  = 1;
  localparam int unsigned FL_GT  = 2;
  localparam int unsigned FL_LTU = 3;
  localparam int unsigned FL_GTU = 4;

  localparam logic [7:0] LEGACY_LO = 8'h0F;
  localparam logic [7:0] LEGACY_HI = 8'h18;

  typedef enum logic [3:0] {
    BR_EQ  = 4'd0, BR_NE  = 4'd1, BR_LT  = 4'd2, BR_GT  = 4'd3,
    BR_LTU = 4'd4, BR_GTU = 4'd5, BR_GE  = 4'd6, BR_LE  = 4'd7,
    BR_GEU = 4'd8, BR_LEU = 4'd9
  } br_op_e;

  typedef struct packed {
    logic   is_branch;  // short form with a defined condition
    logic   illegal;
    br_op_e op;
  } dec_s;
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int unsigned INST_W = 16,
  parameter int unsigned OFF_W  = 10
) (
  input  logic [INST_W-1:0] inst_i,
  output dec_s              dec_o
);
  localparam int unsigned OP_W   = 4;
  localparam int unsigned OP_LSB = OFF_W;
  localparam int unsigned NUM_OP = 10;

  logic            short_form;
  logic            legacy;
  logic [OP_W-1:0] op_raw;
  logic [7:0]      major;

  assign short_form = (inst_i[INST_W-1 -: 2] == 2'b11);
  assign op_raw     = inst_i[OP_LSB +: OP_W];
  assign major      = inst_i[INST_W-1 -: 8];
  assign legacy     = (inst_i[INST_W-1 -: 2] == 2'b00) &&
                      (major >= LEGACY_LO) && (major <= LEGACY_HI);

  always_comb begin
    dec_o.is_branch = short_form && (op_raw < OP_W'(NUM_OP));
    dec_o.illegal   = legacy || (short_form && (op_raw >= OP_W'(NUM_OP)));
    dec_o.op        = br_op_e'(op_raw);
  end

  // R9
  always_comb begin
    if (!$isunknown(inst_i))
      decode_excl_chk: assert ($onehot0({dec_o.is_branch, dec_o.illegal}));
  end
endmodule

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
(
  input  br_op_e            op_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              met_o
);
  logic eq, lt, gt, ltu, gtu;
  assign eq  = flags_i[FL_EQ];
  assign lt  = flags_i[FL_LT];
  assign gt  = flags_i[FL_GT];
  assign ltu = flags_i[FL_LTU];
  assign gtu = flags_i[FL_GTU];

  always_comb begin
    unique case (op_i)
      BR_EQ:   met_o = eq;
      BR_NE:   met_o = !eq;
      BR_LT:   met_o = lt;
      BR_GT:   met_o = gt;
      BR_LTU:  met_o = ltu;
      BR_GTU:  met_o = gtu;
      BR_GE:   met_o = gt  | eq;
      BR_LE:   met_o = lt  | eq;
      BR_GEU:  met_o = gtu | eq;
      BR_LEU:  met_o = ltu | eq;
      default: met_o = 1'b0;
    endcase
  end

  // R4
  always_comb begin
    if (!$isunknown({op_i, flags_i}) && eq && (op_i >= BR_GE) && (op_i <= BR_LEU))
      or_equal_chk: assert (met_o);
  end
endmodule

// File: rtl/brc_target.sv
module brc_target #(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned STEP_B = 2
) (
  input  logic [PC_W-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             taken_i,
  input  logic             hold_i,
  output logic [PC_W-1:0]  next_pc_o
);
  localparam int unsigned EXT_W = PC_W - OFF_W - 1;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] tgt;
  logic [PC_W-1:0] seq;
  logic [PC_W-1:0] sel;

  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i, 1'b0};
  assign tgt     = pc_i + off_ext;
  assign seq     = pc_i + PC_W'(STEP_B);

  always_comb begin
    if (hold_i)       sel = pc_i;
    else if (taken_i) sel = tgt;
    else              sel = seq;
  end

  assign next_pc_o = {sel[PC_W-1:1], 1'b0};

  // R2
  always_comb begin
    if (!$isunknown({pc_i, off_i}))
      off_range_chk: assert ($signed(off_ext) >= -(2 ** OFF_W) &&
                             $signed(off_ext) <= (2 ** OFF_W) - 2);
  end
endmodule

// File: rtl/brc_unit.sv
module brc_unit
  import brc_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned INST_W  = 16,
  parameter int unsigned OFF_W   = 10,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INST_W-1:0] inst_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [PC_W-1:0]   next_pc_o,
  output logic              taken_o,
  output logic              illegal_o
);
  dec_s            dec;
  logic            cond_met;
  logic            taken_c;
  logic [PC_W-1:0] next_pc_c;

  brc_decode #(.INST_W(INST_W), .OFF_W(OFF_W)) u_dec (
    .inst_i (inst_i),
    .dec_o  (dec)
  );

  brc_cond u_cond (
    .op_i    (dec.op),
    .flags_i (flags_i),
    .met_o   (cond_met)
  );

  assign taken_c = dec.is_branch && cond_met;

  brc_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_tgt (
    .pc_i      (pc_i),
    .off_i     (inst_i[OFF_W-1:0]),
    .taken_i   (taken_c),
    .hold_i    (dec.illegal),
    .next_pc_o (next_pc_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      logic [PC_W-1:0] pc_q;
      logic            taken_q, ill_q, vld_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pc_q    <= '0;
          taken_q <= 1'b0;
          ill_q   <= 1'b0;
          vld_q   <= 1'b0;
        end else begin
          pc_q    <= next_pc_c;
          taken_q <= taken_c;
          ill_q   <= dec.illegal;
          vld_q   <= 1'b1;
        end
      end

      assign next_pc_o = pc_q;
      assign taken_o   = taken_q;
      assign illegal_o = ill_q;

      // R9
      taken_ill_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(taken_o && illegal_o));
      // R7
      ill_hold_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && illegal_o) |-> next_pc_o == {$past(pc_i[PC_W-1:1]), 1'b0});
      // R6
      fallthru_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && !illegal_o && !taken_o) |->
          next_pc_o[PC_W-1:1] == $past(pc_i[PC_W-1:1]) + 1'b1);
      // R10
      even_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        next_pc_o[0] == 1'b0);
      // R7
      ill_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_q && $past(inst_i[INST_W-1 -: 2]) == 2'b11 &&
         $past(inst_i[OFF_W +: 4]) >= 4'd10) |-> (illegal_o && !taken_o));
    end else begin : g_comb
      assign next_pc_o = next_pc_c;
      assign taken_o   = taken_c;
      assign illegal_o = dec.illegal;
    end
  endgenerate
endmodule

// File: tb/sim_brc_unit.sv
module sim_brc_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] inst_i = '0;
  logic [31:0] pc_i = '0;
  logic [4:0]  flags_i = '0;
  logic [31:0] next_pc_o;
  logic        taken_o, illegal_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  brc_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .inst_i(inst_i), .pc_i(pc_i),
    .flags_i(flags_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
    .illegal_o(illegal_o)
  );

  // {inst, pc, flags, exp_pc, exp_taken, exp_ill}
  localparam int NV = 14;
  localparam logic [86:0] VEC [NV] = '{
    {16'hC1FF, 32'h0000_1000, 5'b00001, 32'h0000_13FE, 1'b1, 1'b0}, // R2 R5 beq +1022
    {16'hC1FF, 32'h0000_1000, 5'b00000, 32'h0000_1002, 1'b0, 1'b0}, // R6 beq fails
    {16'hC600, 32'h0000_1000, 5'b00000, 32'h0000_0C00, 1'b1, 1'b0}, // R2 R3 bne -1024
    {16'hCBFF, 32'h0000_0000, 5'b00010, 32'hFFFF_FFFE, 1'b1, 1'b0}, // R5 wrap down
    {16'hD401, 32'hFFFF_FFFE, 5'b10000, 32'h0000_0000, 1'b1, 1'b0}, // R5 wrap up
    {16'hD810, 32'h0000_2000, 5'b00001, 32'h0000_2020, 1'b1, 1'b0}, // R4 ge on eq
    {16'hE410, 32'h0000_2000, 5'b10000, 32'h0000_2002, 1'b0, 1'b0}, // R4 leu on gtu
    {16'hE800, 32'h0000_3000, 5'b11111, 32'h0000_3000, 1'b0, 1'b1}, // R7 op 10
    {16'hFFFF, 32'h0000_4444, 5'b11111, 32'h0000_4444, 1'b0, 1'b1}, // R7 op 15
    {16'h0F00, 32'h0000_5000, 5'b00001, 32'h0000_5000, 1'b0, 1'b1}, // R8 0x0F
    {16'h18AB, 32'h0000_5000, 5'b00001, 32'h0000_5000, 1'b0, 1'b1}, // R8 0x18
    {16'h1900, 32'h0000_6000, 5'b00001, 32'h0000_6002, 1'b0, 1'b0}, // R8 0x19 legal
    {16'h8000, 32'h0000_6000, 5'b11111, 32'h0000_6002, 1'b0, 1'b0}, // R1 other form
    {16'hC001, 32'h0000_1001, 5'b00001, 32'h0000_1002, 1'b1, 1'b0}  // R10 odd pc
  };

  function automatic logic [33:0] model(input logic [15:0] i, input logic [31:0] p,
                                        input logic [4:0] f);
    logic [3:0]  op;
    logic        br, leg, c, tk, il;
    logic [31:0] off, np;
    op  = i[13:10];
    br  = (i[15:14] == 2'b11);
    leg = (i[15:14] == 2'b00) && (i[15:8] >= 8'h0F) && (i[15:8] <= 8'h18);
    case (op)
      4'd0: c = f[0];
      4'd1: c = !f[0];
      4'd2: c = f[1];
      4'd3: c = f[2];
      4'd4: c = f[3];
      4'd5: c = f[4];
      4'd6: c = f[2] | f[0];
      4'd7: c = f[1] | f[0];
      4'd8: c = f[4] | f[0];
      4'd9: c = f[3] | f[0];
      default: c = 1'b0;
    endcase
    il  = leg || (br && op >= 4'd10);
    tk  = br && op < 4'd10 && c;
    off = i[9] ? (32'(i[9:0]) - 32'd1024) : 32'(i[9:0]);
    off = off << 1;
    np  = il ? p : (tk ? p + off : p + 32'd2);
    np[0] = 1'b0;
    return {np, tk, il};
  endfunction

  task automatic check(input string tag, input logic [31:0] epc,
                       input logic etk, input logic eil);
    total++;
    if (next_pc_o !== epc || taken_o !== etk || illegal_o !== eil) begin
      bad++;
      $display("FAIL %s: got pc=%h tk=%b il=%b exp pc=%h tk=%b il=%b",
               tag, next_pc_o, taken_o, illegal_o, epc, etk, eil);
    end
  endtask

  // drive on falling edge, one rising edge registers, sample on next falling edge
  task automatic apply(input logic [15:0] i, input logic [31:0] p, input logic [4:0] f);
    @(negedge clk_i);
    inst_i = i; pc_i = p; flags_i = f;
    @(negedge clk_i);
  endtask

  initial begin
    logic [33:0] e;
    logic [9:0]  offs [4];
    offs[0] = 10'h1FF; offs[1] = 10'h200; offs[2] = 10'h000; offs[3] = 10'h155;

    inst_i = 16'hC1FF; pc_i = 32'h1234_5678; flags_i = 5'b11111;
    repeat (3) @(negedge clk_i);
    check("R11 reset", 32'h0, 1'b0, 1'b0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][86:71], VEC[k][70:39], VEC[k][38:34]);
      check($sformatf("vec%0d R1 R2 R3 R4 R5 R6 R7 R8 R10", k),
            VEC[k][33:2], VEC[k][1], VEC[k][0]);
    end

    // full short-form sweep against the model: R3 R4 R5 R6 R7 R9
    for (int op = 0; op < 16; op++) begin
      for (int f = 0; f < 32; f++) begin
        for (int o = 0; o < 4; o++) begin
          logic [15:0] iw;
          logic [31:0] pw;
          iw = {2'b11, 4'(op), offs[o]};
          pw = (o[0]) ? 32'hFFFF_FFF0 : 32'h0000_0010 + 32'(f * 4);
          apply(iw, pw, 5'(f));
          e = model(iw, pw, 5'(f));
          check($sformatf("R3 R4 R9 op=%0d fl=%0d off=%h", op, f, offs[o]),
                e[33:2], e[1], e[0]);
          if (taken_o && illegal_o) begin
            bad++;
            $display("FAIL R9: tk=%b il=%b exp not both", taken_o, illegal_o);
          end
        end
      end
    end

    // form-1 / form-2 major codes: R8 boundaries and R1 non-branch words
    for (int m = 0; m < 256; m += 1) begin
      logic [15:0] iw;
      if (m[7:6] == 2'b11) continue;
      iw = {8'(m), 8'h5A};
      apply(iw, 32'h0000_7000, 5'b00001);
      e = model(iw, 32'h0000_7000, 5'b00001);
      check($sformatf("R1 R8 major=%h", m), e[33:2], e[1], e[0]);
    end

    // async reset mid-run clears outputs without a clock edge: R11
    apply(16'hC1FF, 32'h0000_1000, 5'b00001);
    check("R11 pre-reset", 32'h0000_13FE, 1'b1, 1'b0);
    #1 rst_ni = 1'b0;
    #1 check("R11 async reset", 32'h0, 1'b0, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(16'hE800, 32'h0000_3002, 5'b00000);
    check("R7 after reset", 32'h0000_3002, 1'b0, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule